// File: doc/BRIEF.md
# Six-Stage Pipeline Interlock Unit

This block is the stall and bypass controller for an in-order integer pipeline with six stages: fetch (0), decode (1), operand-address calculation (2), operand fetch (3), execute (4) and write-back (5). Each cycle the fetch logic presents a short descriptor of the instruction it is fetching. The descriptor holds a valid bit, a destination register, a source register and a flag saying the instruction reads data memory during operand fetch. The unit keeps a copy of each descriptor as the instruction moves down the stages.

From these copies the unit decides, every cycle, which stages must hold, where a bubble goes in, and whether fetch may complete. It also drives the select for the forwarding multiplexer in front of the ALU. Two hazards are covered. The first is a shared memory port: operand fetch and instruction fetch cannot use it in the same cycle. The second is a read-after-write dependency on a register. A mode input chooses between two policies. With the mode clear, a dependent instruction waits until its producer has written back. With the mode set, a dependent instruction takes the producer's result from the bypass.

Top module: `pipe_interlock`

## Requirements
- R1: While `rst` is high, `fetch_en`, `hold`, `bubble` and `fwd_sel` are all zero. After a clock edge with `rst` high, `stage_vld[5:1]` is zero.
- R2: With no hazard, `fetch_en` is 1 and every instruction moves one stage per clock. `stage_vld[k]` shows stage k (k=1..5), and `stage_vld[0]` mirrors `if_vld`.
- R3: With `fwd_en`=0, the instruction in stage 2 stalls if its source equals the destination of a valid instruction in stage 3 or stage 4. A stall sets `hold`=6'b000111 and `bubble`=6'b001000, clears `fetch_en`, and leaves stage 3 empty on the next cycle.
- R4: With `fwd_en`=1, only a valid producer in stage 3 stalls the instruction in stage 2. A producer in stage 4 does not stall it.
- R5: A consumer that directly follows its producer spends 2 cycles with `hold[2]` high when `fwd_en`=0, and 1 cycle when `fwd_en`=1.
- R6: A valid stage-3 instruction with its memory flag set, and no data stall that cycle, clears `fetch_en`. It sets `hold`=6'b000001 and `bubble`=6'b000010, so stage 1 is empty on the next cycle. The resulting cost is one fetch cycle.
- R7: `fwd_sel` is 1 exactly when `fwd_en`=1, stages 3 and 5 are valid, and the stage-5 destination equals the stage-3 source.
- R8: Invalid stages never cause a stall or a forward. Register 0 is compared like any other register.
- R9: Stages ahead of a stalled instruction keep moving. `hold[5:3]` is never set, and a stage-3 instruction reaches stage 4 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = bypass mode, 0 = full interlock |
| if_vld | input | 1 | A valid instruction is being fetched |
| if_dst | input | 3 | Destination register of the fetched instruction |
| if_src | input | 3 | Source register of the fetched instruction |
| if_mem | input | 1 | The fetched instruction reads data memory in operand fetch |
| fetch_en | output | 1 | Fetch completes this cycle |
| hold | output | 6 | Per-stage hold, bit k = stage k |
| bubble | output | 6 | Per-stage bubble insertion for the next cycle |
| stage_vld | output | 6 | Per-stage valid bit |
| fwd_sel | output | 1 | Select the bypassed ALU result for the stage-3 operand |

## Verification
The bench builds the unit with its default 3-bit register identifiers. The random stream draws its registers from only four of the eight, so dependencies fall at every distance between producer and consumer. Memory-flag instructions come in often enough to collide with data stalls, and the bypass mode flips in blocks of cycles. Directed sequences cover the following cases:
- the back-to-back penalty in both modes;
- a register-0 dependency;
- a match against an empty stage;
- a lone memory conflict.

// File: rtl/pil_pkg.sv
package pil_pkg;
    parameter int unsigned REG_W = 3;
    localparam int unsigned NST = 6;

    typedef enum logic [2:0] {
        ST_FE = 3'd0,
        ST_DE = 3'd1,
        ST_AC = 3'd2,
        ST_OF = 3'd3,
        ST_EX = 3'd4,
        ST_WB = 3'd5
    } stage_e;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src;
        logic             mem;
    } instr_t;

    function automatic logic depends(input logic pv, input logic [REG_W-1:0] pd,
                                     input logic [REG_W-1:0] cs);
        return pv && (pd == cs);
    endfunction
endpackage

// File: rtl/pil_stage_regs.sv
module pil_stage_regs
    import pil_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  instr_t               fe_in,
    input  logic [NST-1:0]       hold,
    input  logic [NST-1:0]       bubble,
    output instr_t [NST-1:0]     st
);
    assign st[0] = fe_in;

    for (genvar k = 1; k < NST; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                st[k] <= '0;
            end else if (hold[k]) begin
                st[k] <= st[k];
            end else if (bubble[k]) begin
                st[k] <= '0;
            end else begin
                st[k] <= st[k-1];
            end
        end
    end
endmodule

// File: rtl/pil_hazard.sv
module pil_hazard
    import pil_pkg::*;
(
    input  logic             rst,
    input  logic             fwd_en,
    input  logic             ac_vld,
    input  logic [REG_W-1:0] ac_src,
    input  logic             of_vld,
    input  logic [REG_W-1:0] of_dst,
    input  logic             of_mem,
    input  logic             ex_vld,
    input  logic [REG_W-1:0] ex_dst,
    output logic [NST-1:0]   hold,
    output logic [NST-1:0]   bubble,
    output logic             fetch_en
);
    logic raw_stall;
    logic port_clash;

    always_comb begin
        raw_stall  = ac_vld && (depends(of_vld, of_dst, ac_src) ||
                                (!fwd_en && depends(ex_vld, ex_dst, ac_src)));
        port_clash = of_vld && of_mem;
        hold       = '0;
        bubble     = '0;
        if (!rst) begin
            if (raw_stall) begin
                for (int k = 0; k <= int'(ST_AC); k++) hold[k] = 1'b1;
                bubble[ST_OF] = 1'b1;
            end else if (port_clash) begin
                hold[ST_FE]   = 1'b1;
                bubble[ST_DE] = 1'b1;
            end
        end
        fetch_en = !rst && !hold[ST_FE];
    end
endmodule

// File: rtl/pil_fwd.sv
module pil_fwd
    import pil_pkg::*;
(
    input  logic             rst,
    input  logic             fwd_en,
    input  logic             of_vld,
    input  logic [REG_W-1:0] of_src,
    input  logic             wb_vld,
    input  logic [REG_W-1:0] wb_dst,
    output logic             fwd_sel
);
    always_comb begin
        fwd_sel = !rst && fwd_en && of_vld && depends(wb_vld, wb_dst, of_src);
    end
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pil_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fwd_en,
    input  logic             if_vld,
    input  logic [REG_W-1:0] if_dst,
    input  logic [REG_W-1:0] if_src,
    input  logic             if_mem,
    output logic             fetch_en,
    output logic [NST-1:0]   hold,
    output logic [NST-1:0]   bubble,
    output logic [NST-1:0]   stage_vld,
    output logic             fwd_sel
);
    instr_t          fe_in;
    instr_t [NST-1:0] st;

    assign fe_in = '{vld: if_vld, dst: if_dst, src: if_src, mem: if_mem};

    pil_stage_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .fe_in  (fe_in),
        .hold   (hold),
        .bubble (bubble),
        .st     (st)
    );

    pil_hazard u_haz (
        .rst      (rst),
        .fwd_en   (fwd_en),
        .ac_vld   (st[ST_AC].vld),
        .ac_src   (st[ST_AC].src),
        .of_vld   (st[ST_OF].vld),
        .of_dst   (st[ST_OF].dst),
        .of_mem   (st[ST_OF].mem),
        .ex_vld   (st[ST_EX].vld),
        .ex_dst   (st[ST_EX].dst),
        .hold     (hold),
        .bubble   (bubble),
        .fetch_en (fetch_en)
    );

    pil_fwd u_fwd (
        .rst     (rst),
        .fwd_en  (fwd_en),
        .of_vld  (st[ST_OF].vld),
        .of_src  (st[ST_OF].src),
        .wb_vld  (st[ST_WB].vld),
        .wb_dst  (st[ST_WB].dst),
        .fwd_sel (fwd_sel)
    );

    for (genvar k = 0; k < NST; k++) begin : g_vld
        assign stage_vld[k] = st[k].vld;
    end
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk
    import pil_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           fwd_en,
    input logic           if_vld,
    input logic           fetch_en,
    input logic [NST-1:0] hold,
    input logic [NST-1:0] bubble,
    input logic [NST-1:0] stage_vld,
    input logic           fwd_sel
);
    // R1
    reset_flush_chk: assert property (@(posedge clk) rst |=> (stage_vld[5:1] == '0));
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |-> (!fetch_en && hold == '0 && bubble == '0 && !fwd_sel));
    // R2
    fetch_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && if_vld) |=> stage_vld[1]);
    // R3
    stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        hold[2] |=> !stage_vld[3]);
    // R4
    fwd_stall_src_chk: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && hold[2]) |-> stage_vld[3]);
    // R6
    fetch_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_en && !hold[1]) |=> !stage_vld[1]);
    // R7
    fwd_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_sel |-> (fwd_en && stage_vld[3] && stage_vld[5]));
    // R9
    ahead_moves_chk: assert property (@(posedge clk) disable iff (rst)
        hold[2] |=> (stage_vld[4] == $past(stage_vld[3])));
endmodule

bind pipe_interlock pipe_interlock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fwd_en    (fwd_en),
    .if_vld    (if_vld),
    .fetch_en  (fetch_en),
    .hold      (hold),
    .bubble    (bubble),
    .stage_vld (stage_vld),
    .fwd_sel   (fwd_sel)
);

// File: tb/pipe_interlock_tb.sv
`timescale 1ns/1ps
module pipe_interlock_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       fwd_en;
    logic       if_vld;
    logic [2:0] if_dst;
    logic [2:0] if_src;
    logic       if_mem;
    logic       fetch_en;
    logic [5:0] hold;
    logic [5:0] bubble;
    logic [5:0] stage_vld;
    logic       fwd_sel;

    always #2 clk = ~clk;

    pipe_interlock u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model of stages 1..5
    logic       mv [1:5];
    logic [2:0] md [1:5];
    logic [2:0] ms [1:5];
    logic       mm [1:5];

    // current fetch descriptor
    logic       cv, cm, cf;
    logic [2:0] cd, cs;
    logic       acc;
    int         h2_cnt, fs_cnt, fe_lo_cnt;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int k = 1; k <= 5; k++) begin
            mv[k] = 0; md[k] = 0; ms[k] = 0; mm[k] = 0;
        end
    endtask

    task automatic step();
        bit ds, sc, efe, efw;
        logic [5:0] eh, eb;
        logic       nv [1:5];
        logic [2:0] nd [1:5];
        logic [2:0] ns [1:5];
        logic       nm [1:5];
        string      tag;
        @(negedge clk);
        if_vld = cv; if_dst = cd; if_src = cs; if_mem = cm; fwd_en = cf;
        #1;
        ds  = mv[2] && ((mv[3] && md[3] == ms[2]) || (!cf && mv[4] && md[4] == ms[2]));
        sc  = mv[3] && mm[3];
        eh  = ds ? 6'b000111 : (sc ? 6'b000001 : 6'b0);
        eb  = ds ? 6'b001000 : (sc ? 6'b000010 : 6'b0);
        efe = !(ds || sc);
        efw = cf && mv[3] && mv[5] && (md[5] == ms[3]);
        tag = ds ? (cf ? "R4" : "R3") : (sc ? "R6" : "R2");
        chk(hold == eh, {tag, " hold"}, hold, eh);
        chk(bubble == eb, {tag, " bubble"}, bubble, eb);
        chk(fetch_en == efe, {tag, " fetch_en"}, fetch_en, efe);
        chk(fwd_sel == efw, "R7 fwd_sel", fwd_sel, efw);
        chk(stage_vld == {mv[5], mv[4], mv[3], mv[2], mv[1], cv}, "R2 stage_vld",
            stage_vld, {mv[5], mv[4], mv[3], mv[2], mv[1], cv});
        chk(hold[5:3] == 3'b0, "R9 upper hold", hold[5:3], 0);
        if (hold[2]) h2_cnt++;
        if (fwd_sel) fs_cnt++;
        if (!fetch_en) fe_lo_cnt++;
        for (int k = 5; k >= 1; k--) begin
            if (eh[k]) begin
                nv[k] = mv[k]; nd[k] = md[k]; ns[k] = ms[k]; nm[k] = mm[k];
            end else if (eb[k]) begin
                nv[k] = 0; nd[k] = 0; ns[k] = 0; nm[k] = 0;
            end else if (k == 1) begin
                nv[k] = cv; nd[k] = cd; ns[k] = cs; nm[k] = cm;
            end else begin
                nv[k] = mv[k-1]; nd[k] = md[k-1]; ns[k] = ms[k-1]; nm[k] = mm[k-1];
            end
        end
        acc = efe;
        @(posedge clk);
        for (int k = 1; k <= 5; k++) begin
            mv[k] = nv[k]; md[k] = nd[k]; ms[k] = ns[k]; mm[k] = nm[k];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        cv = 0; cd = 0; cs = 0; cm = 0;
        if_vld = 0; if_dst = 0; if_src = 0; if_mem = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        chk(fetch_en == 0, "R1 fetch_en in reset", fetch_en, 0);
        chk(hold == 0 && bubble == 0, "R1 hold/bubble in reset", {hold, bubble}, 0);
        chk(fwd_sel == 0, "R1 fwd_sel in reset", fwd_sel, 0);
        chk(stage_vld[5:1] == 0, "R1 stages empty", stage_vld[5:1], 0);
        @(posedge clk);
        #1 rst = 0;
        model_clear();
    endtask

    // feed one instruction until accepted
    task automatic issue(input logic v, input logic [2:0] d, input logic [2:0] s, input logic m);
        cv = v; cd = d; cs = s; cm = m;
        do step(); while (!acc);
    endtask

    task automatic drain(input int n);
        cv = 0; cd = 3'd7; cs = 3'd6; cm = 0;
        repeat (n) step();
    endtask

    task automatic pair_test(input logic f, input logic [2:0] r, input int exp_h,
                             input int exp_f, input string req);
        cf = f;
        drain(6);
        h2_cnt = 0; fs_cnt = 0;
        issue(1, r, 3'd5, 0);
        issue(1, 3'd1, r, 0);
        drain(8);
        chk(h2_cnt == exp_h, {req, " stall cycles"}, h2_cnt, exp_h);
        chk(fs_cnt == exp_f, {req, " forward cycles"}, fs_cnt, exp_f);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; fwd_en = 0; cf = 0;
        if_vld = 0; if_dst = 0; if_src = 0; if_mem = 0;
        model_clear();
        do_reset();

        // R5 back-to-back dependency penalty, both modes
        pair_test(0, 3'd2, 2, 0, "R5 no-bypass");
        pair_test(1, 3'd2, 1, 1, "R5 bypass");
        // R8 register 0 behaves like any register
        pair_test(0, 3'd0, 2, 0, "R8 reg0");

        // R8 empty stage with matching destination causes nothing
        cf = 0; drain(6); h2_cnt = 0;
        issue(0, 3'd3, 3'd0, 1);
        issue(1, 3'd1, 3'd3, 0);
        drain(8);
        chk(h2_cnt == 0, "R8 invalid producer stall", h2_cnt, 0);

        // R6 lone memory conflict costs one fetch cycle
        drain(6); fe_lo_cnt = 0;
        issue(1, 3'd4, 3'd5, 1);
        issue(1, 3'd6, 3'd7, 0);
        drain(8);
        chk(fe_lo_cnt == 1, "R6 fetch cycles lost", fe_lo_cnt, 1);

        // random mix
        for (int blk = 0; blk < 12; blk++) begin
            cf = blk[0];
            for (int i = 0; i < 250; i++) begin
                if (acc || !cv) begin
                    cv = ($urandom_range(0, 7) != 0);
                    cd = 3'($urandom_range(0, 3));
                    cs = 3'($urandom_range(0, 3));
                    cm = ($urandom_range(0, 5) == 0);
                end
                step();
            end
        end

        // reset mid-stream
        cv = 1; cd = 3'd1; cs = 3'd1; step(); step();
        do_reset();
        drain(2);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule